// File: doc/BRIEF.md
# Half-Precision to Single-Precision Widener

This block widens a 16-bit half-precision floating-point value into the 32-bit single-precision value that represents exactly the same number. Widening never loses information, so the block does no rounding. A mode pin selects how the half input is read. In the standard IEEE reading, the top exponent code stands for infinity and NaN. In the alternative reading, that same exponent code is one more ordinary binade of normal numbers. This gives a wider range, and in that reading no input is ever an infinity or a NaN.

Each cycle the block takes at most one value, marked by an input valid bit, and presents the result one clock later with an output valid bit. There is no ready signal and therefore no back-pressure. The stage accepts a value on every cycle in which `in_valid` is high. The consumer must take each result in the cycle in which `out_valid` is high, because the next accepted input overwrites it. When the input is a signalling NaN, an invalid flag travels with the result.

Top module: `hpw_widen`

## Requirements
- R1: In IEEE mode (`alt_mode`=0), a half input with exponent field bits [14:10] in 1..30 gives a single result with the same sign, exponent (e+112), and the half fraction bits [9:0] placed in single fraction bits [22:13], with zeros below.
- R2: In IEEE mode, exponent 31 with fraction 0 gives a signed infinity: exponent 0xFF, fraction 0, sign kept.
- R3: In IEEE mode, exponent 31 with a nonzero fraction gives a quiet NaN. Its sign is kept, its exponent is 0xFF, single fraction bit 22 is set, and half fraction bits [8:0] appear in single fraction bits [21:13].
- R4: `out_invalid` is 1 exactly when the accepted input was, in IEEE mode, exponent 31 with a nonzero fraction and half fraction bit 9 clear (a signalling NaN). Every other input gives 0.
- R5: In alternative mode (`alt_mode`=1), exponent 31 is a normal binade. The result exponent is 143 and the fraction is copied as in R1. No result in this mode is an infinity or a NaN, and no flag is raised.
- R6: A half input with exponent 0 and a nonzero fraction (subnormal) gives a normal single value equal to fraction x 2^-24, in both modes.
- R7: A half zero of either sign gives a single zero of the same sign, in both modes.
- R8: `out_valid` equals `in_valid` delayed by one clock. The result and flag for an input accepted at edge N appear after edge N.
- R9: After an edge with `in_valid`=0, `out_single` and `out_invalid` keep their previous values.
- R10: While `rst` is high at a clock edge, `out_valid`, `out_single` and `out_invalid` are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input value present this cycle |
| alt_mode | input | 1 | 0 = IEEE reading, 1 = alternative reading of exponent 31 |
| in_half | input | 16 | Half-precision input: sign [15], exponent [14:10], fraction [9:0] |
| out_valid | output | 1 | Result present (one cycle after `in_valid`) |
| out_single | output | 32 | Single-precision result: sign [31], exponent [30:23], fraction [22:0] |
| out_invalid | output | 1 | Result came from a signalling NaN input |

## Verification
Two inputs are the hardest to reach from the ports. The first is the signalling NaN: it needs IEEE mode, exponent 31, a nonzero fraction and a clear top fraction bit all at once, and only it may raise the flag. The second is exponent 31 in alternative mode, where the same bit pattern must produce a finite number. The stimulus gets there by streaming every one of the 65536 half encodings under each mode, one per cycle. A final cycle with valid low and a scrambled input shows that the stored result holds.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

  typedef enum logic [2:0] {
    HCLS_ZERO,
    HCLS_SUB,
    HCLS_NORM,
    HCLS_INF,
    HCLS_NAN
  } hcls_e;

endpackage

// File: rtl/hpw_classify.sv
module hpw_classify
  import hpw_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic [EXP_W+FRAC_W:0] bits_in,
  input  logic                  alt_mode,
  output hcls_e                 cls,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W-1:0]     frac_f
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic exp_max, exp_min, frac_nz;

  assign sign    = bits_in[W-1];
  assign exp_f   = bits_in[W-2 -: EXP_W];
  assign frac_f  = bits_in[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    if (exp_min)
      cls = frac_nz ? HCLS_SUB : HCLS_ZERO;
    else if (exp_max && !alt_mode)
      cls = frac_nz ? HCLS_NAN : HCLS_INF;
    else
      cls = HCLS_NORM;
  end

endmodule

// File: rtl/hpw_lzc.sv
module hpw_lzc #(
  parameter int W = 10,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] cnt
);
  logic [W-1:0][CNT_W-1:0] cand;

  for (genvar g = 0; g < W; g++) begin : g_cand
    assign cand[g] = CNT_W'(W - 1 - g);
  end

  always_comb begin
    cnt = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = cand[i];
    end
  end

endmodule

// File: rtl/hpw_assemble.sv
module hpw_assemble
  import hpw_pkg::*;
#(
  parameter int IN_EXP_W   = 5,
  parameter int IN_FRAC_W  = 10,
  parameter int OUT_EXP_W  = 8,
  parameter int OUT_FRAC_W = 23,
  localparam int LZ_W      = $clog2(IN_FRAC_W + 1),
  localparam int OUT_W     = OUT_EXP_W + OUT_FRAC_W + 1
) (
  input  hcls_e                  cls,
  input  logic                   sign,
  input  logic [IN_EXP_W-1:0]    exp_f,
  input  logic [IN_FRAC_W-1:0]   frac_f,
  input  logic [LZ_W-1:0]        lz,
  output logic [OUT_W-1:0]       word,
  output logic                   invalid
);
  localparam int IN_BIAS   = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS  = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF = OUT_BIAS - IN_BIAS;
  localparam int PAD_W     = OUT_FRAC_W - IN_FRAC_W;

  logic [OUT_EXP_W-1:0]  e_out;
  logic [OUT_FRAC_W-1:0] f_out;
  logic [IN_FRAC_W-1:0]  sub_frac;
  logic [LZ_W-1:0]       sub_shift;

  assign sub_shift = lz + LZ_W'(1);
  assign sub_frac  = frac_f << sub_shift;

  always_comb begin
    e_out   = '0;
    f_out   = '0;
    invalid = 1'b0;
    unique case (cls)
      HCLS_ZERO: begin
        e_out = '0;
        f_out = '0;
      end
      HCLS_SUB: begin
        e_out = OUT_EXP_W'(BIAS_DIFF) - OUT_EXP_W'(lz);
        f_out = {sub_frac, {PAD_W{1'b0}}};
      end
      HCLS_NORM: begin
        e_out = OUT_EXP_W'(BIAS_DIFF) + OUT_EXP_W'(exp_f);
        f_out = {frac_f, {PAD_W{1'b0}}};
      end
      HCLS_INF: begin
        e_out = '1;
        f_out = '0;
      end
      HCLS_NAN: begin
        e_out   = '1;
        f_out   = {1'b1, frac_f[IN_FRAC_W-2:0], {PAD_W{1'b0}}};
        invalid = ~frac_f[IN_FRAC_W-1];
      end
      default: begin
        e_out = '0;
        f_out = '0;
      end
    endcase
  end

  assign word = {sign, e_out, f_out};

endmodule

// File: rtl/hpw_widen.sv
module hpw_widen
  import hpw_pkg::*;
#(
  parameter int HALF_EXP_W  = 5,
  parameter int HALF_FRAC_W = 10,
  parameter int SGL_EXP_W   = 8,
  parameter int SGL_FRAC_W  = 23,
  localparam int HALF_W     = HALF_EXP_W + HALF_FRAC_W + 1,
  localparam int SGL_W      = SGL_EXP_W + SGL_FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              alt_mode,
  input  logic [HALF_W-1:0] in_half,
  output logic              out_valid,
  output logic [SGL_W-1:0]  out_single,
  output logic              out_invalid
);
  localparam int LZ_W = $clog2(HALF_FRAC_W + 1);

  hcls_e                  cls;
  logic                   sign;
  logic [HALF_EXP_W-1:0]  exp_f;
  logic [HALF_FRAC_W-1:0] frac_f;
  logic [LZ_W-1:0]        lz;
  logic [SGL_W-1:0]       word_d;
  logic                   invalid_d;

  hpw_classify #(.EXP_W(HALF_EXP_W), .FRAC_W(HALF_FRAC_W)) u_cls (
    .bits_in (in_half),
    .alt_mode(alt_mode),
    .cls     (cls),
    .sign    (sign),
    .exp_f   (exp_f),
    .frac_f  (frac_f)
  );

  hpw_lzc #(.W(HALF_FRAC_W)) u_lzc (
    .vec(frac_f),
    .cnt(lz)
  );

  hpw_assemble #(
    .IN_EXP_W  (HALF_EXP_W),
    .IN_FRAC_W (HALF_FRAC_W),
    .OUT_EXP_W (SGL_EXP_W),
    .OUT_FRAC_W(SGL_FRAC_W)
  ) u_asm (
    .cls    (cls),
    .sign   (sign),
    .exp_f  (exp_f),
    .frac_f (frac_f),
    .lz     (lz),
    .word   (word_d),
    .invalid(invalid_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_single  <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_single  <= word_d;
        out_invalid <= invalid_d;
      end
    end
  end

endmodule

// File: rtl/hpw_widen_chk.sv
module hpw_widen_chk #(
  parameter int HALF_EXP_W  = 5,
  parameter int HALF_FRAC_W = 10,
  parameter int SGL_EXP_W   = 8,
  parameter int SGL_FRAC_W  = 23,
  localparam int HALF_W     = HALF_EXP_W + HALF_FRAC_W + 1,
  localparam int SGL_W      = SGL_EXP_W + SGL_FRAC_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              alt_mode,
  input logic [HALF_W-1:0] in_half,
  input logic              out_valid,
  input logic [SGL_W-1:0]  out_single,
  input logic              out_invalid
);
  logic snan_in;
  assign snan_in = !alt_mode && (&in_half[HALF_W-2 -: HALF_EXP_W])
                   && (|in_half[HALF_FRAC_W-1:0]) && !in_half[HALF_FRAC_W-1];

  // R8: valid follows input valid by one clock
  assert_valid_delay_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  // R9: idle cycles keep the stored result
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_single) && $stable(out_invalid));

  // R4: only a signalling NaN may raise the flag
  assert_flag_only_snan_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && !snan_in |=> !out_invalid);

  // R5: alternative mode never yields the all-ones exponent or a flag
  assert_alt_finite_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid && alt_mode |=> !out_invalid && !(&out_single[SGL_W-2 -: SGL_EXP_W]));

  // R7: sign travels unchanged
  assert_sign_kept_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_single[SGL_W-1] == $past(in_half[HALF_W-1]));

  // R10: reset clears the outputs
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> !out_valid && out_single == '0 && !out_invalid);

endmodule

bind hpw_widen hpw_widen_chk #(
  .HALF_EXP_W (HALF_EXP_W),
  .HALF_FRAC_W(HALF_FRAC_W),
  .SGL_EXP_W  (SGL_EXP_W),
  .SGL_FRAC_W (SGL_FRAC_W)
) u_chk (.*);

// File: tb/hpw_widen_test.sv
module hpw_widen_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        alt_mode;
  logic [15:0] in_half;
  logic        out_valid;
  logic [31:0] out_single;
  logic        out_invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hpw_widen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .alt_mode(alt_mode),
    .in_half(in_half), .out_valid(out_valid), .out_single(out_single),
    .out_invalid(out_invalid)
  );

  function automatic logic [32:0] model(input logic [15:0] h, input logic alt);
    logic       s;
    int         e, f, m, ex, k, ef, fr;
    s = h[15];
    e = int'(h[14:10]);
    f = int'(h[9:0]);
    if (e == 31 && !alt) begin
      if (f == 0) return {1'b0, s, 8'hFF, 23'd0};
      fr = (f << 13) | (1 << 22);
      return {(f < 512), s, 8'hFF, fr[22:0]};
    end
    if (e == 0 && f == 0) return {1'b0, s, 31'd0};
    m  = (e == 0) ? f : (1024 + f);
    ex = (e == 0) ? -24 : (e - 25);
    k  = 0;
    for (int b = 0; b < 11; b++) if ((m >> b) & 1) k = b;
    ef = k + ex + 127;
    fr = (m << (23 - k)) & 32'h7FFFFF;
    return {1'b0, s, ef[7:0], fr[22:0]};
  endfunction

  function automatic string tag_of(input logic [15:0] h, input logic alt);
    if (h[14:10] == 5'd31 && alt) return "R5";
    if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R2" : "R3";
    if (h[14:10] == 5'd0) return (h[9:0] == 0) ? "R7" : "R6";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_vec(input logic [15:0] h, input logic alt);
    logic [32:0] m;
    m = model(h, alt);
    check(out_valid === 1'b1, "R8", "out_valid", {31'd0, out_valid}, 32'd1);
    check(out_single === m[31:0], tag_of(h, alt), $sformatf("word h=%h alt=%0d", h, alt),
          out_single, m[31:0]);
    check(out_invalid === m[32], alt ? "R5" : "R4", $sformatf("flag h=%h", h),
          {31'd0, out_invalid}, {31'd0, m[32]});
  endtask

  initial begin
    logic [15:0] ph;
    logic        pa;
    rst = 1'b1; in_valid = 1'b0; alt_mode = 1'b0; in_half = 16'h0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10", "reset valid", {31'd0, out_valid}, 32'd0);
    check(out_single === 32'd0, "R10", "reset word", out_single, 32'd0);
    check(out_invalid === 1'b0, "R10", "reset flag", {31'd0, out_invalid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R8", "idle valid", {31'd0, out_valid}, 32'd0);
    in_valid = 1'b1; alt_mode = 1'b0; in_half = 16'h0;
    ph = 16'h0; pa = 1'b0;
    for (int i = 1; i < 131072; i++) begin
      @(negedge clk);
      check_vec(ph, pa);
      ph = i[15:0]; pa = i[16];
      in_half = ph; alt_mode = pa;
    end
    @(negedge clk);
    check_vec(ph, pa);
    // R9: idle cycle with a signalling-NaN pattern on the input
    in_valid = 1'b0; alt_mode = 1'b0; in_half = 16'h7C01;
    @(negedge clk);
    check(out_valid === 1'b0, "R8", "valid drop", {31'd0, out_valid}, 32'd0);
    begin
      logic [32:0] m;
      m = model(ph, pa);
      check(out_single === m[31:0], "R9", "held word", out_single, m[31:0]);
      check(out_invalid === m[32], "R9", "held flag", {31'd0, out_invalid}, {31'd0, m[32]});
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule